// File: doc/BRIEF.md
# Reed-Solomon (255,239) Systematic Encoder

This block turns a stream of 8-bit message symbols into systematic Reed-Solomon codewords of 255 symbols over GF(2^8). A codeword opens with a beat that carries a start marker. Each accepted message symbol is copied to the output one cycle later. The same symbol also drives a 16-stage parity shift register whose feedback taps are fixed constant multipliers.

After the 239th message symbol the encoder closes its input. It then emits the 16 parity symbols on consecutive cycles and flags the last of them. The parity is the remainder of M(x)·x^16 divided by the fixed generator polynomial, so every output word is a multiple of that generator. Input gaps are allowed anywhere in the message phase. A fresh start marker in the middle of a message discards what has been gathered so far and begins a new codeword.

Top module: `rs_lfsr_encoder`

## Requirements
- R1: After reset, out_valid and out_last are 0 and in_ready is 1.
- R2: Each kept message symbol appears on out_data with out_valid high in the cycle after it is accepted, unchanged and in arrival order.
- R3: The 16 cycles after the 239th message symbol carry the parity symbols, with out_valid high and no gaps. The parity is M(x)·x^16 mod g(x), where g(x) is the product of (x + α^j) for j = 0..15. The field is built on the polynomial 0x11D, and α is 0x02. The first message symbol accepted is the coefficient of x^254. Parity is emitted from the x^15 coefficient down to x^0.
- R4: Each 255-symbol output word evaluates to zero at α^0 through α^15.
- R5: out_last is high only with the final (x^0) parity symbol, once per codeword.
- R6: in_ready is low for exactly the 16 cycles that follow the acceptance of the 239th message symbol, and high otherwise.
- R7: While no codeword is open, beats without the start marker are accepted and discarded, and they produce no output.
- R8: A beat with the start marker inside an open message clears the parity register and becomes message symbol 1 of a new codeword.
- R9: The codeword length is fixed at 239 message symbols. Cycles with in_valid low, and the level of in_eop, do not change the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input symbol valid |
| in_ready | output | 1 | Encoder can take a symbol |
| in_data | input | 8 | Message symbol |
| in_sop | input | 1 | First symbol of a codeword |
| in_eop | input | 1 | Final message symbol marker (informational) |
| out_valid | output | 1 | Output symbol valid |
| out_data | output | 8 | Message or parity symbol |
| out_last | output | 1 | Final parity symbol of the codeword |

## Verification
The bench drives three kinds of message: an all-zero message, whose parity must be all zero, and a single 1 in the lowest message position, whose parity must equal the generator's own coefficients. A design with a wrong tap, a wrong tap order or reversed feedback fails the impulse case. Random messages are sent with random input gaps and stray in_eop levels, and the syndromes of each word are checked. A design that miscounts the message length or reacts to in_eop shifts the parity and leaves nonzero syndromes. Further cases check that in_ready falls for exactly 16 cycles, that stray beats before a start marker produce no output, and that a start marker in mid-message restarts with a cleared register; a design that kept stale parity would produce a word that is not a codeword.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;
    localparam int SYM_W  = 8;
    localparam int N_PAR  = 16;
    localparam int K_MSG  = 239;
    localparam logic [SYM_W-1:0] PRIM_LOW = 8'h1D;
    localparam int CNT_W  = $clog2(K_MSG + 1);
    localparam int PCNT_W = $clog2(N_PAR);

    typedef logic [SYM_W-1:0] sym_t;
    typedef logic [N_PAR-1:0][SYM_W-1:0] par_vec_t;
    typedef enum logic [1:0] {ST_IDLE, ST_MSG, ST_PAR} enc_state_t;

    function automatic sym_t gf_mul(sym_t a, sym_t b);
        sym_t p = '0;
        sym_t x = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) p = p ^ x;
            x = {x[SYM_W-2:0], 1'b0} ^ (x[SYM_W-1] ? PRIM_LOW : '0);
        end
        return p;
    endfunction

    function automatic sym_t alpha_pow(int e);
        sym_t r = 8'h01;
        for (int i = 0; i < e; i++) r = gf_mul(r, 8'h02);
        return r;
    endfunction

    // Coefficients g0..g15 of the monic generator (x+a^0)..(x+a^15)
    function automatic par_vec_t gen_taps();
        sym_t g [N_PAR+1];
        par_vec_t t;
        for (int i = 0; i <= N_PAR; i++) g[i] = '0;
        g[0] = 8'h01;
        for (int j = 0; j < N_PAR; j++) begin
            sym_t aj = alpha_pow(j);
            for (int i = N_PAR; i >= 1; i--) g[i] = g[i-1] ^ gf_mul(g[i], aj);
            g[0] = gf_mul(g[0], aj);
        end
        for (int i = 0; i < N_PAR; i++) t[i] = g[i];
        return t;
    endfunction

    localparam par_vec_t GEN_TAPS = gen_taps();
endpackage

// File: rtl/gf_const_mul.sv
module gf_const_mul
    import rs_enc_pkg::*;
#(
    parameter sym_t COEF = 8'h01
) (
    input  sym_t a,
    output sym_t y
);
    always_comb y = gf_mul(a, COEF);
endmodule

// File: rtl/rs_parity_lfsr.sv
module rs_parity_lfsr
    import rs_enc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic clr,
    input  logic shift,
    input  sym_t din,
    output sym_t top_stage
);
    par_vec_t par, base, prod;
    sym_t     fb;

    always_comb begin
        base = clr ? '0 : par;
        fb   = shift ? '0 : (din ^ base[N_PAR-1]);
    end

    for (genvar i = 0; i < N_PAR; i++) begin : g_tap
        gf_const_mul #(.COEF(GEN_TAPS[i])) u_mul (.a(fb), .y(prod[i]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            par <= '0;
        end else if (step) begin
            par[0] <= prod[0];
            for (int i = 1; i < N_PAR; i++) par[i] <= base[i-1] ^ prod[i];
        end
    end

    assign top_stage = par[N_PAR-1];

    // R3: shifting out feeds zeros into the lowest stage
    p_shift_zero_fill_r3: assert property (@(posedge clk) disable iff (rst)
        (step && shift) |=> (par[0] == '0));
endmodule

// File: rtl/rs_enc_ctrl.sv
module rs_enc_ctrl
    import rs_enc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_sop,
    output logic in_ready,
    output logic take,
    output logic clr,
    output logic in_par,
    output logic final_par
);
    enc_state_t        state;
    logic [CNT_W-1:0]  cnt, cnt_nxt;
    logic [PCNT_W-1:0] pcnt;

    always_comb begin
        in_ready  = (state != ST_PAR);
        take      = in_valid && in_ready && ((state == ST_MSG) || in_sop);
        clr       = take && in_sop;
        in_par    = (state == ST_PAR);
        final_par = in_par && (pcnt == PCNT_W'(N_PAR - 1));
        cnt_nxt   = in_sop ? CNT_W'(1) : cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            pcnt  <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_MSG: if (take) begin
                    if (cnt_nxt == CNT_W'(K_MSG)) begin
                        state <= ST_PAR;
                        cnt   <= '0;
                        pcnt  <= '0;
                    end else begin
                        state <= ST_MSG;
                        cnt   <= cnt_nxt;
                    end
                end
                default: begin
                    pcnt <= pcnt + PCNT_W'(1);
                    if (final_par) state <= ST_IDLE;
                end
            endcase
        end
    end

    // R9: message counter never reaches the codeword length while open
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
        cnt < CNT_W'(K_MSG));
endmodule

// File: rtl/rs_lfsr_encoder.sv
module rs_lfsr_encoder
    import rs_enc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_sop,
    input  logic       in_eop,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_last
);
    logic take, clr, in_par, final_par, eop_seen;
    sym_t top_stage;

    assign eop_seen = in_eop;

    rs_enc_ctrl u_ctrl (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop),
        .in_ready(in_ready), .take(take), .clr(clr),
        .in_par(in_par), .final_par(final_par)
    );

    rs_parity_lfsr u_lfsr (
        .clk(clk), .rst(rst), .step(take || in_par), .clr(clr),
        .shift(in_par), .din(in_data), .top_stage(top_stage)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else begin
            out_valid <= take || in_par;
            out_last  <= final_par;
            if (in_par)    out_data <= top_stage;
            else if (take) out_data <= in_data;
        end
    end

    // R5: last flag only accompanies a valid symbol
    p_last_valid_r5: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);
    // R3: the last parity symbol is preceded by a valid symbol
    p_last_follows_burst_r3: assert property (@(posedge clk) disable iff (rst)
        out_last |-> $past(out_valid));
    // R6: input reopens together with the final parity symbol
    p_ready_after_last_r6: assert property (@(posedge clk) disable iff (rst)
        out_last |-> in_ready);
    // R6: input closes only right after a message symbol was taken
    p_close_after_msg_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(in_ready) |-> out_valid);
    // R9: eop level never changes readiness by itself
    p_eop_neutral_r9: assert property (@(posedge clk) disable iff (rst)
        (eop_seen && !in_valid && in_ready) |=> in_ready);
endmodule

// File: tb/rs_lfsr_encoder_test.sv
module rs_lfsr_encoder_test;
    localparam int CLK_PERIOD = 10;
    localparam int K = 239;
    localparam int NP = 16;
    localparam int NW = 255;

    logic clk = 0, rst = 1;
    logic in_valid = 0, in_sop = 0, in_eop = 0;
    logic [7:0] in_data = 0;
    logic in_ready, out_valid, out_last;
    logic [7:0] out_data;

    int errors = 0, checks = 0, cycles = 0;

    logic [7:0] cap [0:299];
    logic       rdy [0:299];
    int idx = 0, last_at = -1, last_cnt = 0;
    logic [7:0] msg [0:K-1];
    logic [7:0] gtap [0:NP];

    always #(CLK_PERIOD/2) clk = ~clk;

    rs_lfsr_encoder uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
    );

    always @(negedge clk) begin
        if (!rst && out_valid && idx < 300) begin
            cap[idx] = out_data;
            rdy[idx] = in_ready;
            if (out_last) begin last_at = idx; last_cnt++; end
            idx++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic [7:0] fmul(logic [7:0] a, logic [7:0] b);
        logic [7:0] r = 0;
        logic [15:0] p = 0;
        for (int i = 0; i < 8; i++) if (b[i]) p ^= 16'(a) << i;
        for (int i = 15; i >= 8; i--) if (p[i]) p ^= 16'h11D << (i - 8);
        r = p[7:0];
        return r;
    endfunction

    function automatic logic [7:0] apow(int e);
        logic [7:0] r = 1;
        for (int i = 0; i < e; i++) r = fmul(r, 8'h02);
        return r;
    endfunction

    task automatic build_gen();
        for (int i = 0; i <= NP; i++) gtap[i] = 0;
        gtap[0] = 1;
        for (int j = 0; j < NP; j++) begin
            logic [7:0] nw [0:NP];
            for (int i = 0; i <= NP; i++) nw[i] = fmul(gtap[i], apow(j));
            for (int i = 1; i <= NP; i++) nw[i] ^= gtap[i-1];
            for (int i = 0; i <= NP; i++) gtap[i] = nw[i];
        end
    endtask

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(logic [7:0] d, logic s, logic e);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1; in_data = d; in_sop = s; in_eop = e;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 0; in_sop = 0; in_eop = $urandom % 2;
        end
    endtask

    task automatic send_msg(bit gaps);
        for (int i = 0; i < K; i++) begin
            put(msg[i], i == 0, gaps ? 1'($urandom % 2) : (i == K - 1));
            if (gaps && ($urandom % 4 == 0)) idle(1 + $urandom % 3);
        end
        idle(1);
    endtask

    task automatic wait_done();
        int t = 0;
        while (last_cnt == 0 && t < 400) begin @(negedge clk); t++; end
        idle(2);
    endtask

    task automatic verify(int base, string tag);
        logic [7:0] r [0:NW-1];
        int bad = 0, rbad = 0;
        logic [7:0] s;
        for (int i = 0; i < NW; i++) r[i] = (i < K) ? msg[i] : 8'h00;
        for (int i = 0; i < K; i++) begin
            logic [7:0] c = r[i];
            for (int j = 0; j <= NP; j++) r[i+j] ^= fmul(c, gtap[NP-j]);
        end
        for (int i = 0; i < K; i++) if (cap[base+i] !== msg[i]) bad++;
        check(bad == 0, {"R2 ", tag}, bad, 0);
        bad = 0;
        for (int i = K; i < NW; i++) if (cap[base+i] !== r[i]) bad++;
        check(bad == 0, {"R3 ", tag}, bad, 0);
        bad = 0;
        for (int j = 0; j < NP; j++) begin
            s = 0;
            for (int i = 0; i < NW; i++) s = fmul(s, apow(j)) ^ cap[base+i];
            if (s != 0) bad++;
        end
        check(bad == 0, {"R4 ", tag}, bad, 0);
        check(last_cnt == 1 && last_at == base + NW - 1, {"R5 ", tag},
              last_at, base + NW - 1);
        for (int i = base + K - 1; i < base + NW - 1; i++) if (rdy[i] !== 1'b0) rbad++;
        if (rdy[base+NW-1] !== 1'b1) rbad++;
        check(rbad == 0, {"R6 ", tag}, rbad, 0);
        check(idx == base + NW, {"R3 count ", tag}, idx, base + NW);
    endtask

    task automatic reset_cap();
        idx = 0; last_at = -1; last_cnt = 0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        build_gen();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(out_valid == 0 && out_last == 0 && in_ready == 1, "R1 reset",
              {out_valid, out_last, in_ready}, 3'b001);

        // Zero message: parity all zero
        for (int i = 0; i < K; i++) msg[i] = 0;
        reset_cap(); send_msg(0); wait_done(); verify(0, "zero");

        // Impulse at x^16 gives the generator taps as parity
        msg[K-1] = 8'h01;
        reset_cap(); send_msg(0); wait_done(); verify(0, "impulse");
        begin
            int bad = 0;
            for (int i = 0; i < NP; i++) if (cap[K+i] !== gtap[NP-1-i]) bad++;
            check(bad == 0, "R3 taps", bad, 0);
        end

        // Random messages with gaps and stray eop (R9)
        for (int w = 0; w < 5; w++) begin
            for (int i = 0; i < K; i++) msg[i] = 8'($urandom);
            reset_cap(); send_msg(1); wait_done(); verify(0, "R9 random");
        end

        // R7: beats without start marker while idle are dropped
        reset_cap();
        for (int i = 0; i < 5; i++) put(8'($urandom), 0, 0);
        idle(6);
        check(idx == 0, "R7 dropped", idx, 0);
        for (int i = 0; i < K; i++) msg[i] = 8'($urandom);
        reset_cap(); send_msg(0); wait_done(); verify(0, "R7 after");

        // R8: restart inside an open message
        reset_cap();
        for (int i = 0; i < 10; i++) put(8'($urandom) | 8'h01, i == 0, 0);
        for (int i = 0; i < K; i++) msg[i] = 8'($urandom);
        send_msg(1); wait_done(); verify(10, "R8 restart");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule